// File: doc/BRIEF.md
# Reconfigurable Cell Array Configuration Port

This block is the digital side of the configuration path into an array of reconfigurable cells. A host opens a transaction with a single-cycle start pulse that carries a cell address. For a write, it then supplies three 16-bit beats. The beats are joined into one 48-bit configuration word, and that word is stored into the addressed cell. The cell also receives a one-cycle select pulse.

For a read, the host picks one of four readable cells through the two low address bits. The block then streams that cell's stored 48-bit word out on a single serial pin. While a transaction runs, a busy flag is high and further start pulses are dropped. The block keeps the stored configuration of every cell and presents all of them on a wide flattened output bus.

Top module: `cfg_port`

## Requirements
- R1: After reset every cell word is zero, no select line is high, busy is low and the serial output is low.
- R2: The address is sampled only in the cycle where start is high. Later values on the address input do not affect the transaction.
- R3: A write transaction starts when start is high with the read input low. It then captures one 16-bit beat on each clock edge with the write strobe high, most significant beat first: bits [47:32], then [31:16], then [15:0]. The addressed cell holds the joined word from the edge that captures the third beat. With no idle cycles, the transaction spans four clock periods.
- R4: Cycles with the write strobe low during a write transaction capture nothing and only stretch the transaction.
- R5: The select line of the addressed cell is high for exactly one cycle, the cycle after the third beat's edge. At most one select line is ever high.
- R6: A cell word changes only together with its select pulse. A cell whose transaction has not yet received its third beat keeps its old word, and all other cells keep theirs.
- R7: Writes to addresses 66 to 127 consume their three beats but raise no select line and change no cell.
- R8: A read transaction starts when start is high with the read input high. Address bits [1:0] = n select cell 9*n (cells 0, 9, 18, 27). Its word appears on the serial output most significant bit first, bit 47-j during the j-th cycle after the start edge, for 48 cycles. The serial output is low when idle.
- R9: Busy is high from the edge that accepts a start until the transaction ends: the third beat's edge for a write, 48 cycles for a read. Start pulses and write strobes that arrive while busy, or write strobes that arrive while idle, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle transaction start |
| addr_i | input | 7 | Cell address, valid with start_i |
| wr_i | input | 1 | Data beat strobe |
| rd_i | input | 1 | High with start_i selects a read transaction |
| data_i | input | 16 | Configuration beat |
| cell_sel_o | output | 66 | One-hot select pulse, one bit per cell |
| cell_cfg_o | output | 3168 | Stored 48-bit word of each cell, cell i at bits [48*i+47:48*i] |
| ser_o | output | 1 | Serial readback data |
| busy_o | output | 1 | Transaction in progress |

## Verification
The bench builds the block with its defaults: 66 cells, three 16-bit beats, and four readable cells spaced nine apart. With these values the last valid cell 65, the first dropped address 66, the top address 127, and every one of the four readable cells can all be hit directly. A scoreboard queues each accepted transaction together with a full image of all cell words. It compares the serial stream, the select vector and every cell word when the transaction ends. Directed cases cover a gapped write with a mid-transaction look at the target cell, a start pulse injected during a read, and strobes issued while idle.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int CFG_CELLS     = 66;
    localparam int CFG_ADDR_W    = 7;
    localparam int CFG_BEAT_W    = 16;
    localparam int CFG_BEATS     = 3;
    localparam int CFG_RD_CELLS  = 4;
    localparam int CFG_RD_STRIDE = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic commit;
        logic rd_load;
        logic shift;
        logic busy;
    } seq_ctl_t;

    function automatic int rd_cell_index(input int slot, input int stride);
        return slot * stride;
    endfunction

endpackage

// File: rtl/cfg_seq.sv
module cfg_seq
    import cfgp_pkg::*;
#(
    parameter int ADDR_W   = CFG_ADDR_W,
    parameter int BEAT_W   = CFG_BEAT_W,
    parameter int BEATS    = CFG_BEATS,
    parameter int RD_CELLS = CFG_RD_CELLS,
    localparam int WORD_W  = BEAT_W * BEATS,
    localparam int BUF_W   = WORD_W - BEAT_W,
    localparam int CNT_W   = $clog2(WORD_W),
    localparam int BCNT_W  = $clog2(BEATS),
    localparam int RSEL_W  = $clog2(RD_CELLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BEAT_W-1:0] data_i,
    output seq_ctl_t          ctl_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] word_o,
    output logic [RSEL_W-1:0] rsel_o
);

    seq_st_e             st_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [BCNT_W-1:0]   beat_q;
    logic [CNT_W-1:0]    bit_q;
    logic [BUF_W-1:0]    buf_q;
    logic [WORD_W-1:0]   joined;
    logic                last_beat;
    logic                last_bit;

    assign joined    = {buf_q, data_i};
    assign last_beat = (beat_q == BCNT_W'(BEATS - 1));
    assign last_bit  = (bit_q == CNT_W'(WORD_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            beat_q <= '0;
            bit_q  <= '0;
            buf_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q <= addr_i;
                        beat_q <= '0;
                        bit_q  <= '0;
                        st_q   <= rd_i ? ST_READ : ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (wr_i) begin
                        if (last_beat) begin
                            st_q <= ST_IDLE;
                        end else begin
                            buf_q  <= joined[BUF_W-1:0];
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (last_bit) st_q  <= ST_IDLE;
                    else          bit_q <= bit_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.commit  = (st_q == ST_WRITE) && wr_i && last_beat;
        ctl_o.rd_load = (st_q == ST_IDLE) && start_i && rd_i;
        ctl_o.shift   = (st_q == ST_READ);
        ctl_o.busy    = (st_q != ST_IDLE);
    end

    assign addr_o = addr_q;
    assign word_o = joined;
    assign rsel_o = addr_i[RSEL_W-1:0];

endmodule

// File: rtl/cfg_cell_bank.sv
module cfg_cell_bank #(
    parameter int CELLS  = cfgp_pkg::CFG_CELLS,
    parameter int ADDR_W = cfgp_pkg::CFG_ADDR_W,
    parameter int WORD_W = cfgp_pkg::CFG_BEAT_W * cfgp_pkg::CFG_BEATS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    commit_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [WORD_W-1:0]       word_i,
    output logic [CELLS-1:0]        sel_o,
    output logic [CELLS*WORD_W-1:0] cfg_o
);

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        logic              hit;
        logic              sel_q;
        logic [WORD_W-1:0] cfg_q;

        assign hit = commit_i && (addr_i == ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q <= 1'b0;
                cfg_q <= '0;
            end else begin
                sel_q <= hit;
                if (hit) cfg_q <= word_i;
            end
        end

        assign sel_o[i]                 = sel_q;
        assign cfg_o[i*WORD_W +: WORD_W] = cfg_q;
    end

endmodule

// File: rtl/cfg_readback.sv
module cfg_readback #(
    parameter int RD_CELLS = cfgp_pkg::CFG_RD_CELLS,
    parameter int WORD_W   = cfgp_pkg::CFG_BEAT_W * cfgp_pkg::CFG_BEATS,
    localparam int RSEL_W  = $clog2(RD_CELLS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_i,
    input  logic                       shift_i,
    input  logic                       busy_i,
    input  logic [RSEL_W-1:0]          sel_i,
    input  logic [RD_CELLS*WORD_W-1:0] cand_i,
    output logic                       ser_o
);

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= cand_i[int'(sel_i)*WORD_W +: WORD_W];
        end else if (shift_i) begin
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign ser_o = busy_i & sh_q[WORD_W-1];

endmodule

// File: rtl/cfg_port.sv
module cfg_port
    import cfgp_pkg::*;
#(
    parameter int CELLS     = CFG_CELLS,
    parameter int ADDR_W    = CFG_ADDR_W,
    parameter int BEAT_W    = CFG_BEAT_W,
    parameter int BEATS     = CFG_BEATS,
    parameter int RD_CELLS  = CFG_RD_CELLS,
    parameter int RD_STRIDE = CFG_RD_STRIDE,
    localparam int WORD_W   = BEAT_W * BEATS,
    localparam int RSEL_W   = $clog2(RD_CELLS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    wr_i,
    input  logic                    rd_i,
    input  logic [BEAT_W-1:0]       data_i,
    output logic [CELLS-1:0]        cell_sel_o,
    output logic [CELLS*WORD_W-1:0] cell_cfg_o,
    output logic                    ser_o,
    output logic                    busy_o
);

    seq_ctl_t                   ctl;
    logic [ADDR_W-1:0]          tgt_addr;
    logic [WORD_W-1:0]          word;
    logic [RSEL_W-1:0]          rsel;
    logic [RD_CELLS*WORD_W-1:0] cand;

    cfg_seq #(
        .ADDR_W   (ADDR_W),
        .BEAT_W   (BEAT_W),
        .BEATS    (BEATS),
        .RD_CELLS (RD_CELLS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .addr_i  (addr_i),
        .data_i  (data_i),
        .ctl_o   (ctl),
        .addr_o  (tgt_addr),
        .word_o  (word),
        .rsel_o  (rsel)
    );

    cfg_cell_bank #(
        .CELLS  (CELLS),
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .commit_i (ctl.commit),
        .addr_i   (tgt_addr),
        .word_i   (word),
        .sel_o    (cell_sel_o),
        .cfg_o    (cell_cfg_o)
    );

    for (genvar r = 0; r < RD_CELLS; r++) begin : g_cand
        localparam int CELL_IX = rd_cell_index(r, RD_STRIDE);
        assign cand[r*WORD_W +: WORD_W] = cell_cfg_o[CELL_IX*WORD_W +: WORD_W];
    end

    cfg_readback #(
        .RD_CELLS (RD_CELLS),
        .WORD_W   (WORD_W)
    ) u_rb (
        .clk     (clk),
        .rst     (rst),
        .load_i  (ctl.rd_load),
        .shift_i (ctl.shift),
        .busy_i  (ctl.busy),
        .sel_i   (rsel),
        .cand_i  (cand),
        .ser_o   (ser_o)
    );

    assign busy_o = ctl.busy;

endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
    parameter int CELLS  = cfgp_pkg::CFG_CELLS,
    parameter int WORD_W = cfgp_pkg::CFG_BEAT_W * cfgp_pkg::CFG_BEATS
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    busy_o,
    input logic                    ser_o,
    input logic [CELLS-1:0]        cell_sel_o,
    input logic [CELLS*WORD_W-1:0] cell_cfg_o
);

    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cell_sel_o));

    p_sel_single_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        (|cell_sel_o) |=> !(|cell_sel_o));

    p_cfg_moves_with_sel_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(cell_cfg_o) |-> (|cell_sel_o));

    p_sel_ends_write_r3: assert property (@(posedge clk) disable iff (rst)
        (|cell_sel_o) |-> (!busy_o && $past(busy_o)));

    p_ser_quiet_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !ser_o);

endmodule

bind cfg_port cfg_port_chk #(
    .CELLS  (CELLS),
    .WORD_W (WORD_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_o     (busy_o),
    .ser_o      (ser_o),
    .cell_sel_o (cell_sel_o),
    .cell_cfg_o (cell_cfg_o)
);

// File: tb/tb_cfg_port.sv
module tb_cfg_port;

    localparam int CELLS  = 66;
    localparam int WORD_W = 48;
    localparam int FLAT   = CELLS * WORD_W;

    typedef struct packed {
        logic            rd;
        logic [6:0]      addr;
        logic [47:0]     w;
        logic [FLAT-1:0] snap;
    } item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [6:0]       addr_i = '0;
    logic             wr_i = 1'b0;
    logic             rd_i = 1'b0;
    logic [15:0]      data_i = '0;
    logic [CELLS-1:0] cell_sel_o;
    logic [FLAT-1:0]  cell_cfg_o;
    logic             ser_o;
    logic             busy_o;

    int    vec_cnt = 0;
    int    err_cnt = 0;
    bit    finished = 1'b0;
    item_t q[$];
    logic [FLAT-1:0] mdl = '0;

    cfg_port dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .wr_i       (wr_i),
        .rd_i       (rd_i),
        .data_i     (data_i),
        .cell_sel_o (cell_sel_o),
        .cell_cfg_o (cell_cfg_o),
        .ser_o      (ser_o),
        .busy_o     (busy_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        vec_cnt++;
        if (!ok) begin
            err_cnt++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic cmp_all(input logic [FLAT-1:0] exp, input string req);
        int bad = -1;
        for (int i = CELLS - 1; i >= 0; i--)
            if (cell_cfg_o[i*WORD_W +: WORD_W] !== exp[i*WORD_W +: WORD_W]) bad = i;
        if (bad < 0) chk(1'b1, req, '0, '0);
        else chk(1'b0, req, cell_cfg_o[bad*WORD_W +: WORD_W], exp[bad*WORD_W +: WORD_W]);
    endtask

    // gap: insert idle strobe cycles before the last beat and look at the target cell
    task automatic do_write(input logic [6:0] a, input logic [47:0] w, input bit gap);
        item_t it;
        logic [47:0] old;
        old = (a < CELLS) ? mdl[int'(a)*WORD_W +: WORD_W] : '0;
        if (a < CELLS) mdl[int'(a)*WORD_W +: WORD_W] = w;
        it.rd = 1'b0; it.addr = a; it.w = w; it.snap = mdl;
        q.push_back(it);
        step();
        start_i = 1'b1; addr_i = a; rd_i = 1'b0; wr_i = 1'b0;
        step();
        start_i = 1'b0; addr_i = ~a;  // R2: address no longer valid
        for (int b = 0; b < 3; b++) begin
            if (gap && b == 2) begin
                wr_i = 1'b0; data_i = 16'hdead;
                step(); step();
                if (a < CELLS)
                    chk(cell_cfg_o[int'(a)*WORD_W +: WORD_W] === old, "R6 atomic update, R4 gap",
                        cell_cfg_o[int'(a)*WORD_W +: WORD_W], old);
                chk(busy_o === 1'b1, "R4 busy during gap", busy_o, 1);
                step();
            end
            wr_i = 1'b1;
            data_i = w[47 - 16*b -: 16];
            step();
        end
        wr_i = 1'b0; data_i = '0;
        repeat (3) step();
    endtask

    task automatic do_read(input logic [6:0] a, input bit inject);
        item_t it;
        it.rd = 1'b1; it.addr = a;
        it.w = mdl[int'(a[1:0])*9*WORD_W +: WORD_W];
        it.snap = mdl;
        q.push_back(it);
        step();
        start_i = 1'b1; rd_i = 1'b1; addr_i = a;
        step();
        start_i = 1'b0; rd_i = 1'b0; addr_i = ~a;
        if (inject) begin
            repeat (5) step();
            start_i = 1'b1; wr_i = 1'b1; data_i = 16'hbeef; addr_i = 7'd0;
            step();
            start_i = 1'b0; wr_i = 1'b0; data_i = '0;
        end
        repeat (56) step();
    endtask

    // monitor / scoreboard
    initial begin
        logic busy_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && busy_o && !busy_prev) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9 unexpected transaction", 1, 0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    if (it.rd) begin
                        logic [47:0] got;
                        got[47] = ser_o;
                        for (int j = 1; j < 48; j++) begin
                            @(negedge clk);
                            got[47-j] = ser_o;
                        end
                        @(negedge clk);
                        chk(busy_o === 1'b0, "R9 read busy length", busy_o, 0);
                        chk(got === it.w, "R8 serial readback", got, it.w);
                    end else begin
                        logic [CELLS-1:0] es;
                        while (busy_o) @(negedge clk);
                        es = (it.addr < CELLS) ? (CELLS'(1) << it.addr) : '0;
                        chk(cell_sel_o === es, (it.addr < CELLS) ? "R5 select pulse" : "R7 no select",
                            cell_sel_o, es);
                        cmp_all(it.snap, (it.addr < CELLS) ? "R2,R3 word stored, R6 others kept" :
                                                             "R7 no cell change");
                        @(negedge clk);
                        chk(cell_sel_o === '0, "R5 select one cycle", cell_sel_o, 0);
                    end
                end
            end
            busy_prev = busy_o;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        err_cnt++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk(cell_sel_o === '0, "R1 select", cell_sel_o, 0);
        cmp_all('0, "R1 cell words");
        chk(busy_o === 1'b0, "R1 busy", busy_o, 0);
        chk(ser_o === 1'b0, "R1 serial", ser_o, 0);

        do_write(7'd0, 48'h8123_4567_89ab, 1'b0);
        do_read(7'b1111100, 1'b0);
        do_write(7'd9, 48'hfedc_ba98_7654, 1'b0);
        do_write(7'd18, 48'h0000_ffff_0001, 1'b0);
        do_write(7'd27, 48'haaaa_5555_c3c3, 1'b0);
        do_read(7'd1, 1'b0);
        do_read(7'd6, 1'b0);
        do_read(7'd7, 1'b0);
        do_write(7'd65, 48'h1357_9bdf_2468, 1'b0);
        do_write(7'd66, 48'hffff_ffff_ffff, 1'b0);
        do_write(7'd127, 48'h0f0f_0f0f_0f0f, 1'b0);
        do_write(7'd18, 48'h8000_0000_0001, 1'b1);
        do_read(7'd2, 1'b1);
        do_write(7'd0, 48'h7777_0000_eeee, 1'b0);
        do_read(7'd0, 1'b0);

        // R9: strobes while idle capture nothing
        for (int b = 0; b < 3; b++) begin
            wr_i = 1'b1; data_i = 16'h1234 + 16'(b);
            step();
        end
        wr_i = 1'b0;
        repeat (3) step();
        chk(busy_o === 1'b0, "R9 idle strobes no busy", busy_o, 0);
        cmp_all(mdl, "R9 idle strobes no change");

        repeat (5) step();
        chk(q.size() == 0, "R9 all transactions seen", q.size(), 0);
        finish_run();
    end

endmodule